// File: doc/BRIEF.md
# Two-Thread Four-Lane Issue Arbiter

This block sits between the decode window and the execution lanes of a processor core that runs two hardware threads. Each cycle, each thread offers the two oldest decoded instructions of its window. Each instruction is tagged as scalar or as vector/matrix, and each carries one destination register field and two source register fields. The arbiter decides which of these instructions enter the four shared execution lanes. It registers that decision for the issue stage. It also tells the front end how many instructions each thread may retire from its window.

There are two issue modes. In scalar mode, both threads share the lanes. A thread issues its first instruction, and also its second one when the second does not read the first's result. In vector mode, a single vector/matrix instruction takes all four lanes, one element operation per lane. When both threads hold such an instruction at the head of their windows, a priority pointer decides which one goes. The pointer hands priority to the other thread after every vector issue.

Top module: `dual_issue_arbiter`

## Requirements
- R1: While reset is high, and on the first output after reset, every lane is idle, every tid, slot and vector flag is 0, both consume counts are 0, and thread 0 holds vector priority.
- R2: Each decision appears on the outputs one clock after its inputs are sampled. Lane k is bit k of each lane vector. In scalar mode, lane 0 and lane 1 carry thread 0 slots 0 and 1, and lane 2 and lane 3 carry thread 1 slots 0 and 1. Idle lanes show tid 0 and slot 0. A thread whose two slots are valid, scalar and independent issues both of them and reports a consume count of 2, so up to four scalars issue in one cycle.
- R3: If either source of a thread's slot 1 equals the nonzero destination of its slot 0, only slot 0 issues and that thread's consume count is 1.
- R4: Register 0 never creates a dependency: a slot 0 destination of 0 that matches a slot 1 source still lets both slots issue.
- R5: A valid vector/matrix instruction in slot 0 of either thread selects vector mode. All four lanes become valid, every lane's tid is the issuing thread, every slot is 0, the vector flag is 1, and that thread's consume count is 1.
- R6: When both threads have a vector/matrix instruction in slot 0, the thread holding priority issues. Back-to-back contested cycles therefore alternate between the threads.
- R7: The priority pointer changes only when a vector instruction issues, and it then passes to the thread that did not issue. Scalar-only cycles leave it unchanged.
- R8: In a vector cycle, the other thread issues nothing and its consume count is 0, whether it holds scalar or vector work.
- R9: A vector/matrix instruction in slot 1 does not start vector mode. It stays in the window while the scalar in slot 0 issues alone, giving a consume count of 1.
- R10: An invalid slot 0 makes its thread issue nothing (count 0), even if slot 1 is valid. An invalid slot 1 limits its thread to slot 0 (count 1).
- Input packing: instruction i = 2*thread + slot occupies bit i of `ins_valid`/`ins_vec` and bits [i*REG_W +: REG_W] of each register field bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 4 | Per-instruction valid, index 2*thread+slot |
| ins_vec | input | 4 | Per-instruction vector/matrix tag |
| ins_dst | input | 4*REG_W | Destination register fields |
| ins_src_a | input | 4*REG_W | First source register fields |
| ins_src_b | input | 4*REG_W | Second source register fields |
| lane_valid | output | 4 | Lane carries an operation this cycle |
| lane_tid | output | 4 | Thread owning each lane |
| lane_slot | output | 4 | Window slot feeding each lane |
| lane_vec | output | 1 | Lanes carry one vector/matrix instruction |
| consume_t0 | output | 2 | Thread 0 instructions leaving the window (0..2) |
| consume_t1 | output | 2 | Thread 1 instructions leaving the window (0..2) |

## Verification
The embedded assertions check, on every cycle, several properties. A vector cycle fills all four lanes with a single owner, and the idle thread consumes nothing. A dependent scalar pair collapses to one instruction. The priority pointer holds still unless a vector instruction issues. Two contested vector cycles in a row pick different threads. Only the directed scenarios can show the rest: the exact lane-to-slot mapping, the register 0 exception, the pointer surviving a run of scalar cycles, and the treatment of a vector instruction waiting behind a scalar or behind an invalid slot.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_THREADS = 2;
  localparam int WIN_SLOTS   = 2;
  localparam int NUM_LANES   = NUM_THREADS * WIN_SLOTS;
  typedef logic [1:0] count_t;
endpackage

// File: rtl/arb_pair_check.sv
module arb_pair_check
  import arb_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       v,
  input  logic [1:0]       vec,
  input  logic [REG_W-1:0] dst0,
  input  logic [REG_W-1:0] sa1,
  input  logic [REG_W-1:0] sb1,
  output count_t           scalar_cnt,
  output logic             want_vec
);
  logic dst_live;
  logic hazard;

  assign dst_live = |dst0;
  assign hazard   = dst_live && ((sa1 == dst0) || (sb1 == dst0));
  assign want_vec = v[0] & vec[0];

  always_comb begin
    if (!v[0] || vec[0])
      scalar_cnt = 2'd0;
    else if (v[1] && !vec[1] && !hazard)
      scalar_cnt = 2'd2;
    else
      scalar_cnt = 2'd1;
  end

  // R3: a dependent scalar pair never issues both
  p_dep_pair_single_r3: assert property (@(posedge clk) disable iff (rst)
    (v == 2'b11 && vec == 2'b00 && dst0 != '0 && sa1 == dst0) |-> scalar_cnt == 2'd1);
endmodule

// File: rtl/arb_vec_rr.sv
module arb_vec_rr (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] want,
  output logic       winner,
  output logic       any_vec
);
  logic prio;

  assign any_vec = |want;
  assign winner  = (want == 2'b11) ? prio : want[1];

  always_ff @(posedge clk) begin
    if (rst)
      prio <= 1'b0;
    else if (any_vec)
      prio <= ~winner;
  end

  // R7: priority only moves on a vector issue
  p_prio_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !any_vec |=> $stable(prio));

  // R6: two contested cycles in a row choose different threads
  p_contest_alternate_r6: assert property (@(posedge clk) disable iff (rst)
    (want == 2'b11 && $past(want) == 2'b11 && !$past(rst)) |-> winner != $past(winner));
endmodule

// File: rtl/dual_issue_arbiter.sv
module dual_issue_arbiter
  import arb_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_LANES-1:0]       ins_valid,
  input  logic [NUM_LANES-1:0]       ins_vec,
  input  logic [NUM_LANES*REG_W-1:0] ins_dst,
  input  logic [NUM_LANES*REG_W-1:0] ins_src_a,
  input  logic [NUM_LANES*REG_W-1:0] ins_src_b,
  output logic [NUM_LANES-1:0]       lane_valid,
  output logic [NUM_LANES-1:0]       lane_tid,
  output logic [NUM_LANES-1:0]       lane_slot,
  output logic                       lane_vec,
  output logic [1:0]                 consume_t0,
  output logic [1:0]                 consume_t1
);
  count_t               cnt [NUM_THREADS];
  logic [NUM_THREADS-1:0] want;
  logic                 winner;
  logic                 any_vec;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    localparam int S0 = t * WIN_SLOTS;
    localparam int S1 = S0 + 1;
    arb_pair_check #(.REG_W(REG_W)) u_pair (
      .clk       (clk),
      .rst       (rst),
      .v         (ins_valid[S1:S0]),
      .vec       (ins_vec[S1:S0]),
      .dst0      (ins_dst[S0*REG_W +: REG_W]),
      .sa1       (ins_src_a[S1*REG_W +: REG_W]),
      .sb1       (ins_src_b[S1*REG_W +: REG_W]),
      .scalar_cnt(cnt[t]),
      .want_vec  (want[t])
    );
  end

  arb_vec_rr u_rr (
    .clk    (clk),
    .rst    (rst),
    .want   (want),
    .winner (winner),
    .any_vec(any_vec)
  );

  logic [NUM_LANES-1:0] nx_valid, nx_tid, nx_slot;
  count_t               nx_c [NUM_THREADS];

  always_comb begin
    nx_valid = '0;
    nx_tid   = '0;
    nx_slot  = '0;
    for (int t = 0; t < NUM_THREADS; t++) nx_c[t] = 2'd0;
    if (any_vec) begin
      nx_valid     = '1;
      nx_tid       = {NUM_LANES{winner}};
      nx_c[winner] = 2'd1;
    end else begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        nx_c[t] = cnt[t];
        for (int s = 0; s < WIN_SLOTS; s++) begin
          if (cnt[t] > s) begin
            nx_valid[t*WIN_SLOTS+s] = 1'b1;
            nx_tid[t*WIN_SLOTS+s]   = t[0];
            nx_slot[t*WIN_SLOTS+s]  = s[0];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_valid <= '0;
      lane_tid   <= '0;
      lane_slot  <= '0;
      lane_vec   <= 1'b0;
      consume_t0 <= 2'd0;
      consume_t1 <= 2'd0;
    end else begin
      lane_valid <= nx_valid;
      lane_tid   <= nx_tid;
      lane_slot  <= nx_slot;
      lane_vec   <= any_vec;
      consume_t0 <= nx_c[0];
      consume_t1 <= nx_c[1];
    end
  end

  // R5: a vector cycle owns every lane with one consumed instruction
  p_vec_all_lanes_r5: assert property (@(posedge clk) disable iff (rst)
    lane_vec |-> (lane_valid == '1 && lane_slot == '0 &&
                  (lane_tid == '0 || lane_tid == '1) &&
                  ({consume_t0, consume_t1} == 4'b0100 || {consume_t0, consume_t1} == 4'b0001)));

  // R8: the thread that does not issue a vector consumes nothing
  p_vec_other_idle_r8: assert property (@(posedge clk) disable iff (rst)
    lane_vec |-> (lane_tid[0] ? consume_t0 == 2'd0 : consume_t1 == 2'd0));

  // R2: scalar lanes match each thread's consume count
  p_scalar_lanes_r2: assert property (@(posedge clk) disable iff (rst)
    !lane_vec |-> ($countones(lane_valid[1:0]) == consume_t0 &&
                   $countones(lane_valid[3:2]) == consume_t1));

  // R1: decisions seen right after reset are empty
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (lane_valid == '0 && consume_t0 == 2'd0 && consume_t1 == 2'd0 && !lane_vec));
endmodule

// File: tb/dual_issue_arbiter_tb.sv
module dual_issue_arbiter_tb;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    ins_valid = '0;
  logic [3:0]    ins_vec = '0;
  logic [4*RW-1:0] ins_dst = '0, ins_src_a = '0, ins_src_b = '0;
  logic [3:0]    lane_valid, lane_tid, lane_slot;
  logic          lane_vec;
  logic [1:0]    consume_t0, consume_t1;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dual_issue_arbiter #(.REG_W(RW)) u_dut (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_vec(ins_vec),
    .ins_dst(ins_dst), .ins_src_a(ins_src_a), .ins_src_b(ins_src_b),
    .lane_valid(lane_valid), .lane_tid(lane_tid), .lane_slot(lane_slot),
    .lane_vec(lane_vec), .consume_t0(consume_t0), .consume_t1(consume_t1)
  );

  task automatic expect_out(input string req, input logic [3:0] ev, input logic [3:0] et,
                            input logic [3:0] es, input logic evec,
                            input logic [1:0] ec0, input logic [1:0] ec1);
    logic [16:0] act, exp;
    act = {lane_valid, lane_tid, lane_slot, lane_vec, consume_t0, consume_t1};
    exp = {ev, et, es, evec, ec0, ec1};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual v=%b t=%b s=%b vec=%b c0=%0d c1=%0d expected v=%b t=%b s=%b vec=%b c0=%0d c1=%0d",
               req, lane_valid, lane_tid, lane_slot, lane_vec, consume_t0, consume_t1,
               ev, et, es, evec, ec0, ec1);
    end
  endtask

  // independent defaults: dst i+1, sources 10+ never match
  task automatic load_default(input logic [3:0] v, input logic [3:0] vc);
    ins_valid = v;
    ins_vec   = vc;
    for (int i = 0; i < 4; i++) begin
      ins_dst[i*RW +: RW]   = RW'(i + 1);
      ins_src_a[i*RW +: RW] = RW'(i + 10);
      ins_src_b[i*RW +: RW] = RW'(i + 20);
    end
  endtask

  // inputs drive at negedge; registered result checked one negedge later
  task automatic step;
    @(negedge clk);
  endtask

  task automatic t_reset;
    step();
    expect_out("R1 during reset", 4'h0, 4'h0, 4'h0, 1'b0, 2'd0, 2'd0);
    rst = 1'b0;
    step();
    expect_out("R1 after reset", 4'h0, 4'h0, 4'h0, 1'b0, 2'd0, 2'd0);
  endtask

  task automatic t_scalar_full;
    load_default(4'hF, 4'h0); step();
    expect_out("R2 four scalars", 4'hF, 4'b1100, 4'b1010, 1'b0, 2'd2, 2'd2);
  endtask

  task automatic t_dependency;
    load_default(4'hF, 4'h0); ins_src_a[1*RW +: RW] = RW'(1); step();
    expect_out("R3 thread0 src_a hazard", 4'b1101, 4'b1100, 4'b1000, 1'b0, 2'd1, 2'd2);
    load_default(4'hF, 4'h0); ins_src_b[3*RW +: RW] = RW'(3); step();
    expect_out("R3 thread1 src_b hazard", 4'b0111, 4'b0100, 4'b0010, 1'b0, 2'd2, 2'd1);
  endtask

  task automatic t_reg_zero;
    load_default(4'hF, 4'h0);
    ins_dst[0*RW +: RW] = '0; ins_src_a[1*RW +: RW] = '0;
    ins_dst[2*RW +: RW] = '0; ins_src_b[3*RW +: RW] = '0;
    step();
    expect_out("R4 register zero", 4'hF, 4'b1100, 4'b1010, 1'b0, 2'd2, 2'd2);
  endtask

  task automatic t_vec_single;
    load_default(4'hF, 4'b0100); step();
    expect_out("R5 R8 thread1 vector alone", 4'hF, 4'hF, 4'h0, 1'b1, 2'd0, 2'd1);
  endtask

  task automatic t_vec_contest;
    load_default(4'hF, 4'b0101); step();
    expect_out("R6 contest first t0", 4'hF, 4'h0, 4'h0, 1'b1, 2'd1, 2'd0);
    step();
    expect_out("R6 R8 contest then t1", 4'hF, 4'hF, 4'h0, 1'b1, 2'd0, 2'd1);
    step();
    expect_out("R6 contest back to t0", 4'hF, 4'h0, 4'h0, 1'b1, 2'd1, 2'd0);
  endtask

  task automatic t_prio_hold;
    load_default(4'hF, 4'h0); step(); step();
    expect_out("R7 scalar gap", 4'hF, 4'b1100, 4'b1010, 1'b0, 2'd2, 2'd2);
    load_default(4'hF, 4'b0101); step();
    expect_out("R7 priority kept by t1", 4'hF, 4'hF, 4'h0, 1'b1, 2'd0, 2'd1);
  endtask

  task automatic t_vec_slot1;
    load_default(4'hF, 4'b0010); step();
    expect_out("R9 vector behind scalar", 4'b1101, 4'b1100, 4'b1000, 1'b0, 2'd1, 2'd2);
  endtask

  task automatic t_invalid;
    load_default(4'b1110, 4'h0); step();
    expect_out("R10 slot0 invalid", 4'b1100, 4'b1100, 4'b1000, 1'b0, 2'd0, 2'd2);
    load_default(4'b0111, 4'h0); step();
    expect_out("R10 slot1 invalid", 4'b0111, 4'b0100, 4'b0010, 1'b0, 2'd2, 2'd1);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_scalar_full();
    t_dependency();
    t_reg_zero();
    t_vec_single();
    t_vec_contest();
    t_prio_hold();
    t_vec_slot1();
    t_invalid();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule